// File: doc/BRIEF.md
# Serial NAND Page Operation Sequencer

This block runs whole page reads, page programs and block erases on a serial NAND device. A front-side client starts an operation with a kind, a row (page) address, a column offset and a byte count. The sequencer then issues a series of command frames to a separate frame engine. That engine handles the serial wire. The sequencer polls the device status byte until the busy flag clears, bounds the polling with a timeout for each kind of operation, and ends with a one-cycle completion pulse and a result code.

Each frame request carries an opcode, up to three address bytes, an optional dummy byte, a data length and a direction. Data bytes flow straight between the client and the frame engine during the data phase of a frame. In a read this is the cache read-out. In a program this is the page load. Poll spacing and timeouts are counted in microseconds, and the microsecond is derived from a clock-cycles-per-microsecond input.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, and whenever no operation is running, `op_busy`, `op_done` and `fe_req` are low.
- R2: A read (kind 0) issues three kinds of frame, in this order. First, opcode 0x13 with the row as a 3-byte address. Next, status polls: opcode 0x0F, 1-byte address 0xC0, one byte read. Last, opcode 0x03 with the column as a 2-byte address, one dummy byte and `op_count` bytes read. The read bytes are passed to `host_rd_data` with `host_rd_valid`.
- R3: A program (kind 1) issues three frames in this order. First, opcode 0x06 with no address. Next, opcode 0x02 with a 2-byte address of 0 and PAGE_BYTES bytes written from `host_wr_data` on `host_wr_ready`. Then opcode 0x10 with the row as a 3-byte address. Status polls follow.
- R4: An erase (kind 2) issues opcode 0x06, then opcode 0xD8 with a 3-byte row whose low log2(BLK_PAGES) bits are cleared, then status polls.
- R5: While a returned status byte has bit 0 set, the poll is repeated.
- R6: For a read, status bits 5:4 give the result. 00 gives code 0 (ok). 01 and 11 give code 1 (corrected). 10 gives code 2 (uncorrectable); no cache read frame is issued and no byte reaches the client.
- R7: For a program, status bit 3 gives code 3 (program fail). Bit 2 has no effect on a program.
- R8: For an erase, status bit 2 gives code 4 (erase fail). Bit 3 has no effect on an erase.
- R9: If a poll returns busy when at least the kind's maximum time in microseconds has passed since polling began, the operation ends with code 5 (timeout).
- R10: Read polls follow each other back to back. Program polls start at least PROG_POLL_US microseconds apart, and erase polls at least ERASE_POLL_US microseconds apart.
- R11: `op_start` is ignored while an operation is running, and it is ignored when the kind is 3.
- R12: `op_done` is a one-cycle pulse with `op_result` valid in that cycle. `op_busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ticks_per_us | input | TPU_W | Clock cycles per microsecond (0 is treated as 1) |
| op_start | input | 1 | Start pulse for an operation |
| op_kind | input | 2 | 0 read, 1 program, 2 erase, 3 unused |
| op_row | input | 24 | Page (row) address |
| op_col | input | 16 | Column offset for reads |
| op_count | input | 16 | Byte count for reads |
| op_busy | output | 1 | Operation in progress |
| op_done | output | 1 | Completion pulse |
| op_result | output | 3 | Result code, valid with op_done |
| host_rd_valid | output | 1 | Read byte valid toward the client |
| host_rd_data | output | 8 | Read byte toward the client |
| host_wr_ready | output | 1 | Write byte taken from the client this cycle |
| host_wr_data | input | 8 | Write byte from the client |
| fe_req | output | 1 | Frame request, held until fe_done |
| fe_opcode | output | 8 | Frame opcode |
| fe_addr | output | 24 | Frame address, right-aligned |
| fe_addr_len | output | 2 | Address bytes (0 to 3) |
| fe_dummy | output | 1 | One dummy byte after the address |
| fe_len | output | 16 | Data bytes in the frame |
| fe_wr | output | 1 | Data phase direction, 1 toward the device |
| fe_done | input | 1 | Frame complete pulse |
| fe_rd_valid | input | 1 | Byte received from the device |
| fe_rd_data | input | 8 | Received byte |
| fe_wr_ready | input | 1 | Engine takes a write byte this cycle |
| fe_wr_data | output | 8 | Write byte toward the engine |

## Verification
A wrong sequencer state shows up within one frame as a wrong opcode, address length or data length on the frame request. It can also show up as a missing or extra cache-read frame, or as data bytes reaching the client when the ECC verdict forbids it. A wrong status decode, or a wrong per-kind choice of fail bit, shows up in the result code on the completion pulse of the same operation. Timer faults show up as status polls that are too close together, or as a timeout that ends polling too early or never. These are observed as the spacing of poll frames and as the total length of a timed-out operation.

// File: rtl/nand_seq_pkg.sv
// Package: shared encodings for the NAND page operation sequencer.
// Assumes: one-byte opcodes and a status byte read at feature address 0xC0.
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_NONE  = 2'd3
    } op_kind_t;

    typedef enum logic [2:0] {
        RES_OK         = 3'd0,
        RES_ECC_FIXED  = 3'd1,
        RES_ECC_BAD    = 3'd2,
        RES_PROG_FAIL  = 3'd3,
        RES_ERASE_FAIL = 3'd4,
        RES_TIMEOUT    = 3'd5
    } result_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_LOAD,
        ST_MAIN,
        ST_POLL,
        ST_GAP,
        ST_CACHE,
        ST_FIN
    } seq_state_t;

    localparam logic [7:0] OPC_WREN      = 8'h06;
    localparam logic [7:0] OPC_LOAD      = 8'h02;
    localparam logic [7:0] OPC_EXEC      = 8'h10;
    localparam logic [7:0] OPC_PAGE_RD   = 8'h13;
    localparam logic [7:0] OPC_CACHE_RD  = 8'h03;
    localparam logic [7:0] OPC_ERASE     = 8'hD8;
    localparam logic [7:0] OPC_GET_FEAT  = 8'h0F;
    localparam logic [7:0] FEAT_STATUS   = 8'hC0;

endpackage

// File: rtl/nand_us_counter.sv
// Module: microsecond counter.
// Divides the clock by a programmable number of cycles per microsecond and
// counts whole microseconds since the last clear, saturating at the top.
// Assumes: tpu of 0 behaves as 1; clear restarts the divider phase too.
module nand_us_counter #(
    parameter int TPU_W = 8,
    parameter int US_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [TPU_W-1:0] tpu,
    output logic [US_W-1:0]  us
);
    localparam logic [US_W-1:0] US_TOP = '1;

    logic [TPU_W-1:0] pre_q;
    logic [TPU_W-1:0] pre_last;

    // Last divider phase of one microsecond
    always_comb pre_last = (tpu == '0) ? '0 : tpu - TPU_W'(1);

    // Divider and microsecond count
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_q <= '0;
            us    <= '0;
        end else if (pre_q >= pre_last) begin
            pre_q <= '0;
            if (us != US_TOP) us <= us + US_W'(1);
        end else begin
            pre_q <= pre_q + TPU_W'(1);
        end
    end
endmodule

// File: rtl/nand_status_eval.sv
// Module: status byte evaluator.
// Turns a returned status byte into a busy flag and a per-kind verdict.
// Assumes: bit 0 busy, bit 2 erase fail, bit 3 program fail, bits 5:4 ECC.
module nand_status_eval
    import nand_seq_pkg::*;
(
    input  op_kind_t   kind,
    input  logic [7:0] status,
    output logic       dev_busy,
    output result_t    verdict
);
    // Decode busy flag and the fail bit that belongs to this kind
    always_comb begin
        dev_busy = status[0];
        verdict  = RES_OK;
        unique case (kind)
            OP_READ: begin
                unique case (status[5:4])
                    2'b00:   verdict = RES_OK;
                    2'b10:   verdict = RES_ECC_BAD;
                    default: verdict = RES_ECC_FIXED;
                endcase
            end
            OP_PROG:  verdict = status[3] ? RES_PROG_FAIL : RES_OK;
            OP_ERASE: verdict = status[2] ? RES_ERASE_FAIL : RES_OK;
            default:  verdict = RES_OK;
        endcase
    end
endmodule

// File: rtl/nand_frame_build.sv
// Module: frame field builder.
// Forms opcode, address, address length, dummy flag, data length and
// direction for the frame that the current sequencer state requests.
// Assumes: state and operation fields are held stable for the whole frame.
module nand_frame_build
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int BLK_PAGES  = 64
) (
    input  seq_state_t  state,
    input  op_kind_t    kind,
    input  logic [23:0] row,
    input  logic [15:0] col,
    input  logic [15:0] count,
    output logic [7:0]  opcode,
    output logic [23:0] addr,
    output logic [1:0]  addr_len,
    output logic        dummy,
    output logic [15:0] len,
    output logic        wr
);
    localparam logic [23:0] BLK_MASK  = ~(24'(BLK_PAGES) - 24'd1);
    localparam logic [15:0] PAGE_LEN  = 16'(PAGE_BYTES);

    // Field selection per frame state
    always_comb begin
        opcode   = OPC_GET_FEAT;
        addr     = 24'(FEAT_STATUS);
        addr_len = 2'd1;
        dummy    = 1'b0;
        len      = 16'd1;
        wr       = 1'b0;
        unique case (state)
            ST_WREN: begin
                opcode   = OPC_WREN;
                addr     = '0;
                addr_len = 2'd0;
                len      = '0;
                wr       = 1'b1;
            end
            ST_LOAD: begin
                opcode   = OPC_LOAD;
                addr     = '0;
                addr_len = 2'd2;
                len      = PAGE_LEN;
                wr       = 1'b1;
            end
            ST_MAIN: begin
                addr_len = 2'd3;
                len      = '0;
                wr       = 1'b1;
                unique case (kind)
                    OP_PROG: begin
                        opcode = OPC_EXEC;
                        addr   = row;
                    end
                    OP_ERASE: begin
                        opcode = OPC_ERASE;
                        addr   = row & BLK_MASK;
                    end
                    default: begin
                        opcode = OPC_PAGE_RD;
                        addr   = row;
                    end
                endcase
            end
            ST_CACHE: begin
                opcode   = OPC_CACHE_RD;
                addr     = {8'd0, col};
                addr_len = 2'd2;
                dummy    = 1'b1;
                len      = count;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nand_op_seq.sv
// Module: NAND page operation sequencer (top).
// Runs read, program and erase as frame sequences through a frame engine,
// polls status with per-kind spacing and timeout, and reports a result code.
// Assumes: the engine holds a request until fe_done; a status byte arrives
// on fe_rd_valid no later than the fe_done of its frame.
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES    = 2048,
    parameter int BLK_PAGES     = 64,
    parameter int TPU_W         = 8,
    parameter int US_W          = 16,
    parameter int READ_MAX_US   = 70,
    parameter int PROG_MAX_US   = 600,
    parameter int ERASE_MAX_US  = 4000,
    parameter int READ_POLL_US  = 0,
    parameter int PROG_POLL_US  = 100,
    parameter int ERASE_POLL_US = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TPU_W-1:0] cfg_ticks_per_us,
    input  logic             op_start,
    input  logic [1:0]       op_kind,
    input  logic [23:0]      op_row,
    input  logic [15:0]      op_col,
    input  logic [15:0]      op_count,
    output logic             op_busy,
    output logic             op_done,
    output logic [2:0]       op_result,
    output logic             host_rd_valid,
    output logic [7:0]       host_rd_data,
    output logic             host_wr_ready,
    input  logic [7:0]       host_wr_data,
    output logic             fe_req,
    output logic [7:0]       fe_opcode,
    output logic [23:0]      fe_addr,
    output logic [1:0]       fe_addr_len,
    output logic             fe_dummy,
    output logic [15:0]      fe_len,
    output logic             fe_wr,
    input  logic             fe_done,
    input  logic             fe_rd_valid,
    input  logic [7:0]       fe_rd_data,
    input  logic             fe_wr_ready,
    output logic [7:0]       fe_wr_data
);
    seq_state_t      state;
    op_kind_t        kind_q;
    logic [23:0]     row_q;
    logic [15:0]     col_q;
    logic [15:0]     cnt_q;
    result_t         res_q;
    logic [7:0]      stat_q;
    logic [7:0]      stat_now;
    logic            dev_busy;
    result_t         verdict;
    logic [US_W-1:0] elapsed_us;
    logic [US_W-1:0] gap_us;
    logic [US_W-1:0] max_us;
    logic [US_W-1:0] poll_us;
    logic            clr_elapsed;
    logic            clr_gap;

    // Per-kind timeout and poll spacing
    always_comb begin
        unique case (kind_q)
            OP_PROG: begin
                max_us  = US_W'(PROG_MAX_US);
                poll_us = US_W'(PROG_POLL_US);
            end
            OP_ERASE: begin
                max_us  = US_W'(ERASE_MAX_US);
                poll_us = US_W'(ERASE_POLL_US);
            end
            default: begin
                max_us  = US_W'(READ_MAX_US);
                poll_us = US_W'(READ_POLL_US);
            end
        endcase
    end

    // Timer clears: polling window starts after the main command frame
    assign clr_elapsed = (state == ST_MAIN) && fe_done;
    assign clr_gap     = (state == ST_POLL) && fe_done;

    nand_us_counter #(.TPU_W(TPU_W), .US_W(US_W)) u_elapsed (
        .clk(clk), .rst_n(rst_n), .clr(clr_elapsed),
        .tpu(cfg_ticks_per_us), .us(elapsed_us)
    );

    nand_us_counter #(.TPU_W(TPU_W), .US_W(US_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr(clr_gap),
        .tpu(cfg_ticks_per_us), .us(gap_us)
    );

    // Status byte seen in the current poll frame
    assign stat_now = fe_rd_valid ? fe_rd_data : stat_q;

    nand_status_eval u_eval (
        .kind(kind_q), .status(stat_now),
        .dev_busy(dev_busy), .verdict(verdict)
    );

    nand_frame_build #(.PAGE_BYTES(PAGE_BYTES), .BLK_PAGES(BLK_PAGES)) u_frame (
        .state(state), .kind(kind_q), .row(row_q), .col(col_q), .count(cnt_q),
        .opcode(fe_opcode), .addr(fe_addr), .addr_len(fe_addr_len),
        .dummy(fe_dummy), .len(fe_len), .wr(fe_wr)
    );

    // Capture the status byte while a poll frame is running
    always_ff @(posedge clk) begin
        if (!rst_n)                                stat_q <= '0;
        else if (state == ST_POLL && fe_rd_valid)  stat_q <= fe_rd_data;
    end

    // Operation sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= OP_READ;
            row_q  <= '0;
            col_q  <= '0;
            cnt_q  <= '0;
            res_q  <= RES_OK;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (op_start && op_kind != 2'(OP_NONE)) begin
                        kind_q <= op_kind_t'(op_kind);
                        row_q  <= op_row;
                        col_q  <= op_col;
                        cnt_q  <= op_count;
                        state  <= (op_kind == 2'(OP_READ)) ? ST_MAIN : ST_WREN;
                    end
                end
                ST_WREN:  if (fe_done) state <= (kind_q == OP_PROG) ? ST_LOAD : ST_MAIN;
                ST_LOAD:  if (fe_done) state <= ST_MAIN;
                ST_MAIN:  if (fe_done) state <= ST_POLL;
                ST_POLL: begin
                    if (fe_done) begin
                        if (dev_busy) begin
                            if (elapsed_us >= max_us) begin
                                res_q <= RES_TIMEOUT;
                                state <= ST_FIN;
                            end else if (poll_us != '0) begin
                                state <= ST_GAP;
                            end
                        end else begin
                            res_q <= verdict;
                            state <= (kind_q == OP_READ && verdict != RES_ECC_BAD)
                                     ? ST_CACHE : ST_FIN;
                        end
                    end
                end
                ST_GAP:   if (gap_us >= poll_us) state <= ST_POLL;
                ST_CACHE: if (fe_done) state <= ST_FIN;
                ST_FIN:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Front-side status and data passthrough
    assign op_busy       = (state != ST_IDLE);
    assign op_done       = (state == ST_FIN);
    assign op_result     = res_q;
    assign fe_req        = (state == ST_WREN) || (state == ST_LOAD) || (state == ST_MAIN)
                        || (state == ST_POLL) || (state == ST_CACHE);
    assign host_rd_valid = fe_rd_valid && (state == ST_CACHE);
    assign host_rd_data  = fe_rd_data;
    assign host_wr_ready = fe_wr_ready && (state == ST_LOAD);
    assign fe_wr_data    = host_wr_data;

endmodule

// File: rtl/nand_op_seq_chk.sv
// Module: property checker for the NAND page operation sequencer.
// Observes the top-level ports only; attached through bind below.
module nand_op_seq_chk #(
    parameter int BLK_PAGES = 64,
    parameter int TPU_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TPU_W-1:0] cfg_ticks_per_us,
    input logic             op_start,
    input logic [1:0]       op_kind,
    input logic [23:0]      op_row,
    input logic [15:0]      op_col,
    input logic [15:0]      op_count,
    input logic             op_busy,
    input logic             op_done,
    input logic [2:0]       op_result,
    input logic             host_rd_valid,
    input logic [7:0]       host_rd_data,
    input logic             host_wr_ready,
    input logic [7:0]       host_wr_data,
    input logic             fe_req,
    input logic [7:0]       fe_opcode,
    input logic [23:0]      fe_addr,
    input logic [1:0]       fe_addr_len,
    input logic             fe_dummy,
    input logic [15:0]      fe_len,
    input logic             fe_wr,
    input logic             fe_done,
    input logic             fe_rd_valid,
    input logic [7:0]       fe_rd_data,
    input logic             fe_wr_ready,
    input logic [7:0]       fe_wr_data
);
    localparam logic [23:0] LOW_MASK = 24'(BLK_PAGES) - 24'd1;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_busy |-> !fe_req && !op_done);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fe_req && !fe_done |=> fe_req && $stable(fe_opcode) && $stable(fe_addr)
                               && $stable(fe_len));

    assert_rd_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_valid |-> fe_rd_valid && fe_req && !fe_wr);

    assert_wr_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_ready |-> fe_wr_ready && fe_req && fe_wr && fe_opcode == 8'h02);

    assert_erase_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fe_req && fe_opcode == 8'hD8 |-> (fe_addr & LOW_MASK) == 24'd0 && fe_addr_len == 2'd3);

    assert_result_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> op_result <= 3'd5);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done && !op_busy);
endmodule

bind nand_op_seq nand_op_seq_chk #(.BLK_PAGES(BLK_PAGES), .TPU_W(TPU_W)) u_chk (.*);

// File: tb/sim_nand_op_seq.sv
`timescale 1ns/1ps
module sim_nand_op_seq;
    localparam int PAGE_BYTES = 8;
    localparam int BLK_PAGES  = 4;
    localparam int TPU        = 4;
    localparam int RD_MAX     = 20;
    localparam int PG_MAX     = 40;
    localparam int ER_MAX     = 60;
    localparam int PG_POLL    = 2;
    localparam int ER_POLL    = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [23:0] op_row = '0;
    logic [15:0] op_col = '0;
    logic [15:0] op_count = '0;
    logic        op_busy, op_done;
    logic [2:0]  op_result;
    logic        host_rd_valid, host_wr_ready;
    logic [7:0]  host_rd_data, host_wr_data, fe_wr_data;
    logic        fe_req, fe_dummy, fe_wr;
    logic [7:0]  fe_opcode;
    logic [23:0] fe_addr;
    logic [1:0]  fe_addr_len;
    logic [15:0] fe_len;
    logic        fe_done = 1'b0;
    logic        fe_rd_valid = 1'b0;
    logic [7:0]  fe_rd_data = '0;
    logic        fe_wr_ready = 1'b0;

    always #2.5 clk = ~clk;

    nand_op_seq #(
        .PAGE_BYTES(PAGE_BYTES), .BLK_PAGES(BLK_PAGES),
        .READ_MAX_US(RD_MAX), .PROG_MAX_US(PG_MAX), .ERASE_MAX_US(ER_MAX),
        .READ_POLL_US(0), .PROG_POLL_US(PG_POLL), .ERASE_POLL_US(ER_POLL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ticks_per_us(8'(TPU)),
        .op_start(op_start), .op_kind(op_kind), .op_row(op_row), .op_col(op_col),
        .op_count(op_count), .op_busy(op_busy), .op_done(op_done), .op_result(op_result),
        .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
        .host_wr_ready(host_wr_ready), .host_wr_data(host_wr_data),
        .fe_req(fe_req), .fe_opcode(fe_opcode), .fe_addr(fe_addr),
        .fe_addr_len(fe_addr_len), .fe_dummy(fe_dummy), .fe_len(fe_len), .fe_wr(fe_wr),
        .fe_done(fe_done), .fe_rd_valid(fe_rd_valid), .fe_rd_data(fe_rd_data),
        .fe_wr_ready(fe_wr_ready), .fe_wr_data(fe_wr_data)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Frame log kept by the device model
    logic [7:0]  lg_op   [64];
    logic [23:0] lg_addr [64];
    logic [1:0]  lg_alen [64];
    logic        lg_dum  [64];
    logic [15:0] lg_len  [64];
    int          lg_t    [64];
    int nlog = 0;
    int busy_left = 0;
    logic [7:0] final_st = '0;
    int rd_rcv = 0, rd_bad = 0, wr_cnt = 0, wr_bad = 0;
    int t_begin = 0, t_end = 0;
    logic [2:0] res_seen = '0;

    function automatic logic [7:0] rdpat(input int c, input int k);
        return 8'((c + k) * 7 + 3);
    endfunction
    function automatic logic [7:0] wpat(input int k);
        return 8'(k * 13 + 1);
    endfunction

    assign host_wr_data = wpat(wr_cnt);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Device and frame engine model: samples then drives at each falling edge
    initial begin
        int ms, lat, n, c;
        logic [7:0] cop;
        logic [15:0] clen;
        logic cwr;
        ms = 0; lat = 0; n = 0; c = 0; cop = '0; clen = '0; cwr = 1'b0;
        forever begin
            @(negedge clk);
            if (host_rd_valid) begin
                if (host_rd_data != rdpat(c, rd_rcv)) rd_bad++;
                rd_rcv++;
            end
            if (fe_wr_ready && host_wr_ready) begin
                if (fe_wr_data != wpat(wr_cnt)) wr_bad++;
                wr_cnt++;
            end
            case (ms)
                0: begin
                    fe_done = 1'b0;
                    if (fe_req) begin
                        if (nlog < 64) begin
                            lg_op[nlog] = fe_opcode; lg_addr[nlog] = fe_addr;
                            lg_alen[nlog] = fe_addr_len; lg_dum[nlog] = fe_dummy;
                            lg_len[nlog] = fe_len; lg_t[nlog] = cyc;
                        end
                        nlog++;
                        cop = fe_opcode; clen = fe_len; cwr = fe_wr;
                        c = int'(fe_addr);
                        lat = 2; ms = 1;
                    end
                end
                1: begin
                    lat--;
                    if (lat == 0) begin n = 0; ms = 2; end
                end
                default: begin
                    if (n < int'(clen)) begin
                        if (cwr) fe_wr_ready = 1'b1;
                        else begin
                            fe_rd_valid = 1'b1;
                            if (cop == 8'h0F) begin
                                fe_rd_data = (busy_left > 0) ? 8'h01 : final_st;
                                if (busy_left > 0) busy_left--;
                            end else fe_rd_data = rdpat(c, n);
                        end
                        n++;
                    end else begin
                        fe_wr_ready = 1'b0; fe_rd_valid = 1'b0;
                        fe_done = 1'b1; ms = 0;
                    end
                end
            endcase
        end
    end

    // Run one operation; optional extra start pulse while it runs
    task automatic run_op(input int kind, input int row, input int col, input int cnt,
                          input int busy, input logic [7:0] st, input bit inject);
        @(negedge clk);
        nlog = 0; rd_rcv = 0; rd_bad = 0; wr_cnt = 0; wr_bad = 0;
        busy_left = busy; final_st = st;
        op_kind = 2'(kind); op_row = 24'(row); op_col = 16'(col); op_count = 16'(cnt);
        op_start = 1'b1; t_begin = cyc;
        @(negedge clk);
        op_start = 1'b0;
        if (inject) begin
            repeat (3) @(negedge clk);
            op_kind = 2'd2; op_row = 24'h00FFFF; op_start = 1'b1;
            @(negedge clk);
            op_start = 1'b0;
        end
        while (!op_done) @(negedge clk);
        res_seen = op_result; t_end = cyc;
        @(negedge clk);
        chk(!op_done && !op_busy, "R12 done pulse and busy drop", int'(op_done), 0);
    endtask

    function automatic int ecc_exp(input int e);
        return (e == 0) ? 0 : (e == 2) ? 2 : 1;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        chk(!op_busy && !op_done && !fe_req, "R1 reset quiet", int'(fe_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!op_busy && !fe_req, "R1 idle after reset", int'(op_busy), 0);

        // R2 R5 R6: sweep of ECC codes and busy poll counts
        for (int e = 0; e < 4; e++) begin
            for (int b = 0; b < 3; b++) begin
                int row, col, cnt, exp_frames, exp_bytes;
                row = 'h100 + e * 7 + b; col = e * 3 + 1; cnt = 3 + b;
                run_op(0, row, col, cnt, b, 8'(e << 4), 1'b0);
                exp_bytes  = (e == 2) ? 0 : cnt;
                exp_frames = 1 + (b + 1) + ((e == 2) ? 0 : 1);
                chk(int'(res_seen) == ecc_exp(e), "R6 read result", int'(res_seen), ecc_exp(e));
                chk(nlog == exp_frames, "R5 read frame count", nlog, exp_frames);
                chk(lg_op[0] == 8'h13 && lg_addr[0] == 24'(row) && lg_alen[0] == 2'd3,
                    "R2 page read frame", int'(lg_op[0]), 'h13);
                chk(lg_op[1] == 8'h0F && lg_addr[1] == 24'hC0 && lg_alen[1] == 2'd1
                    && lg_len[1] == 16'd1, "R2 status frame", int'(lg_addr[1]), 'hC0);
                if (e != 2)
                    chk(lg_op[nlog-1] == 8'h03 && lg_addr[nlog-1] == 24'(col)
                        && lg_alen[nlog-1] == 2'd2 && lg_dum[nlog-1]
                        && lg_len[nlog-1] == 16'(cnt), "R2 cache read frame",
                        int'(lg_op[nlog-1]), 3);
                chk(rd_rcv == exp_bytes && rd_bad == 0, "R6 client bytes", rd_rcv, exp_bytes);
                if (b == 2)
                    chk(lg_t[2] - lg_t[1] < PG_POLL * TPU, "R10 read polls back to back",
                        lg_t[2] - lg_t[1], PG_POLL * TPU - 1);
            end
        end

        // R3 R7: program, clean and with status bit 2 (no effect), with extra start (R11)
        run_op(1, 'h2345, 0, 0, 2, 8'h04, 1'b1);
        chk(res_seen == 3'd0, "R7 program ignores bit 2", int'(res_seen), 0);
        chk(nlog == 6, "R11 program frames unaffected by extra start", nlog, 6);
        chk(lg_op[0] == 8'h06 && lg_alen[0] == 2'd0, "R3 write enable", int'(lg_op[0]), 6);
        chk(lg_op[1] == 8'h02 && lg_addr[1] == 24'd0 && lg_alen[1] == 2'd2
            && lg_len[1] == 16'(PAGE_BYTES), "R3 load frame", int'(lg_len[1]), PAGE_BYTES);
        chk(lg_op[2] == 8'h10 && lg_addr[2] == 24'h2345 && lg_alen[2] == 2'd3,
            "R3 execute frame", int'(lg_addr[2]), 'h2345);
        chk(wr_cnt == PAGE_BYTES && wr_bad == 0, "R3 write bytes", wr_cnt, PAGE_BYTES);
        chk(lg_t[4] - lg_t[3] >= PG_POLL * TPU, "R10 program poll spacing",
            lg_t[4] - lg_t[3], PG_POLL * TPU);
        run_op(1, 'h77, 0, 0, 0, 8'h08, 1'b0);
        chk(res_seen == 3'd3, "R7 program fail", int'(res_seen), 3);

        // R4 R8: erase row masking, fail bit, ignored bit 3
        for (int r = 0; r < 4; r++) begin
            int row;
            row = 'h40 + r * 5;
            run_op(2, row, 0, 0, 1, (r == 0) ? 8'h04 : 8'h08, 1'b0);
            chk(lg_op[0] == 8'h06 && lg_op[1] == 8'hD8 && lg_alen[1] == 2'd3
                && lg_addr[1] == 24'(row - (row % BLK_PAGES)), "R4 erase frame",
                int'(lg_addr[1]), row - (row % BLK_PAGES));
            chk(int'(res_seen) == ((r == 0) ? 4 : 0), "R8 erase result",
                int'(res_seen), (r == 0) ? 4 : 0);
            if (r == 1)
                chk(lg_t[3] - lg_t[2] >= ER_POLL * TPU, "R10 erase poll spacing",
                    lg_t[3] - lg_t[2], ER_POLL * TPU);
        end

        // R9: timeouts on erase and read with a device that stays busy
        run_op(2, 'h80, 0, 0, 100000, 8'h00, 1'b0);
        chk(res_seen == 3'd5, "R9 erase timeout code", int'(res_seen), 5);
        chk(t_end - t_begin >= ER_MAX * TPU && t_end - t_begin <= ER_MAX * TPU + 100,
            "R9 erase timeout length", t_end - t_begin, ER_MAX * TPU);
        run_op(0, 'h81, 2, 4, 100000, 8'h00, 1'b0);
        chk(res_seen == 3'd5 && rd_rcv == 0, "R9 read timeout code", int'(res_seen), 5);
        chk(t_end - t_begin >= RD_MAX * TPU, "R9 read timeout length",
            t_end - t_begin, RD_MAX * TPU);
        busy_left = 0;

        // R11: kind 3 start is ignored
        @(negedge clk);
        nlog = 0; op_kind = 2'd3; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        repeat (10) @(negedge clk);
        chk(!op_busy && nlog == 0, "R11 kind 3 ignored", nlog, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule